// File: doc/BRIEF.md
# Three-Channel Interval and Compare Timer

This block is a register-mapped timer with three identical counter channels. Each channel holds a running count, a reload value and two compare values. Enabled, a channel steps once for each tick of its chosen timebase. The timebase is either an internal enable that fires once every six clock cycles or an external tick pin. A channel counts up or down, as software selects.

When an up-counting channel steps past all ones, or a down-counting channel steps below zero, it takes its reload value and raises an overflow event. A periodic interrupt every P ticks therefore comes from a reload value of all-ones minus (P-1). A compare event is raised when a step lands the count on one of the two compare values. Software can arm a single deadline by writing the current count plus a delta into the first compare register.

The nine events (two compares and an overflow per channel) collect into a sticky status register that software clears by writing ones. A mask register and per-channel overflow interrupt enables select which status bits drive the single interrupt line.

Top module: `tmr3_top`

## Requirements
- R1: After reset every register reads zero, all channels are stopped and `irq` is low; a read of an offset outside the map (anything other than 0x00-0x2C, 0x30, 0x34, 0x38, or any unaligned address) returns zero.
- R2: Channel n (n = 0..2) decodes at base 0x10*n with count at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC; control is at 0x30, status at 0x34 and mask at 0x38. Written values read back, and a count write takes priority over a step in the same cycle (that step and its events are dropped).
- R3: An enabled channel with its direction bit set adds one to its count on each tick of its selected timebase.
- R4: An up-step from 0xFFFFFFFF loads the reload value instead and sets that channel's overflow status bit (bit 3n+2).
- R5: A step whose new count equals compare A sets status bit 3n, and one that equals compare B sets bit 3n+1.
- R6: Status bits are sticky. Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R7: An event that occurs in the same cycle as a write-one-to-clear of its own status bit leaves that bit set.
- R8: `irq` is high when any status bit is set together with its mask bit (1 = enabled). Overflow bits also need the channel's interrupt-enable control bit (bit 3n+2); compare bits do not.
- R9: Clearing a channel's enable bit (control bit 3n) freezes its count; setting it again resumes from the held value.
- R10: With its direction bit (control bit 9+n) clear, a channel subtracts one per tick; a step from zero loads the reload value and sets the overflow status bit.
- R11: With the clock-select bit (control bit 3n+1) clear, a channel steps once every six clock cycles and ignores `ext_tick`; with it set, the channel steps only on cycles where `ext_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ext_tick | input | 1 | External timebase tick, one cycle per step |
| irq | output | 1 | Combined interrupt request |

## Verification
A counter event and a software clear of the same status bit can fall in one cycle. The bench provokes this by presetting channel 0 to all ones and then issuing the status write-one-to-clear in the same cycle as an external tick. It judges the result by reading status back: the overflow bit must still be set. A count write can also coincide with a tick. That case is judged by the count reading exactly the written value, with no step applied after it.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;

    localparam int NCH      = 3;
    localparam int EVT_PER  = 3;
    localparam int NEVT     = NCH * EVT_PER;
    localparam int CTL_W    = 12;
    localparam int DIR_BASE = 9;

    // word index inside a channel bank
    typedef enum logic [1:0] {
        W_CNT  = 2'd0,
        W_LOAD = 2'd1,
        W_CMPA = 2'd2,
        W_CMPB = 2'd3
    } bank_word_e;

    // word index inside the shared bank (bank 3)
    typedef enum logic [1:0] {
        S_CTL  = 2'd0,
        S_STS  = 2'd1,
        S_MSK  = 2'd2,
        S_NONE = 2'd3
    } shared_word_e;

    typedef struct packed {
        logic en;
        logic ext;
        logic ie;
        logic up;
    } ch_ctl_t;

    typedef struct packed {
        logic ovf;
        logic cmpb;
        logic cmpa;
    } ch_evt_t;

    function automatic ch_ctl_t ctl_of(input logic [CTL_W-1:0] c, input int n);
        ch_ctl_t r;
        r.en  = c[EVT_PER*n];
        r.ext = c[EVT_PER*n + 1];
        r.ie  = c[EVT_PER*n + 2];
        r.up  = c[DIR_BASE + n];
        return r;
    endfunction

endpackage

// File: rtl/tmr3_prescale.sv
module tmr3_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;

    assign tick = (div_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/tmr3_channel.sv
module tmr3_channel
    import tmr3_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_ctl_t       ctl,
    input  logic          pre_tick,
    input  logic          ext_tick,
    input  logic          wr_cnt,
    input  logic          wr_load,
    input  logic          wr_cmpa,
    input  logic          wr_cmpb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] load,
    output logic [DW-1:0] cmpa,
    output logic [DW-1:0] cmpb,
    output ch_evt_t       evt
);
    logic          step;
    logic          wrap;
    logic [DW-1:0] nxt;

    assign step = ctl.en && (ctl.ext ? ext_tick : pre_tick) && !wr_cnt;

    always_comb begin
        if (ctl.up) begin
            wrap = (cnt == '1);
            nxt  = wrap ? load : cnt + 1'b1;
        end else begin
            wrap = (cnt == '0);
            nxt  = wrap ? load : cnt - 1'b1;
        end
        evt.ovf  = step && wrap;
        evt.cmpa = step && (nxt == cmpa);
        evt.cmpb = step && (nxt == cmpb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            load <= '0;
            cmpa <= '0;
            cmpb <= '0;
        end else begin
            if (wr_cnt)    cnt  <= wdata;
            else if (step) cnt  <= nxt;
            if (wr_load)   load <= wdata;
            if (wr_cmpa)   cmpa <= wdata;
            if (wr_cmpb)   cmpb <= wdata;
        end
    end
endmodule

// File: rtl/tmr3_top.sv
module tmr3_top
    import tmr3_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 8,
    parameter int PRESC  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ext_tick,
    output logic              irq
);
    logic [1:0]       bank;
    logic [1:0]       word;
    logic             aligned;
    logic             wr;
    logic             pre_tick;

    logic [CTL_W-1:0] ctl_q;
    logic [NEVT-1:0]  sts_q;
    logic [NEVT-1:0]  msk_q;
    logic [NEVT-1:0]  sts_set;
    logic [NEVT-1:0]  sts_clr;
    logic [NEVT-1:0]  irq_gate;

    logic [DW-1:0]    cnt_w  [NCH];
    logic [DW-1:0]    load_w [NCH];
    logic [DW-1:0]    cmpa_w [NCH];
    logic [DW-1:0]    cmpb_w [NCH];

    assign bank    = bus_addr[5:4];
    assign word    = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:6] == '0);
    assign wr      = bus_en && bus_wr && aligned;

    tmr3_prescale #(.DIV(PRESC)) i_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (pre_tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_ctl_t c;
        ch_evt_t e;
        logic    hit;

        assign c   = ctl_of(ctl_q, g);
        assign hit = wr && (bank == 2'(g));

        tmr3_channel #(.DW(DW)) i_ch (
            .clk      (clk),
            .rst      (rst),
            .ctl      (c),
            .pre_tick (pre_tick),
            .ext_tick (ext_tick),
            .wr_cnt   (hit && (word == W_CNT)),
            .wr_load  (hit && (word == W_LOAD)),
            .wr_cmpa  (hit && (word == W_CMPA)),
            .wr_cmpb  (hit && (word == W_CMPB)),
            .wdata    (bus_wdata),
            .cnt      (cnt_w[g]),
            .load     (load_w[g]),
            .cmpa     (cmpa_w[g]),
            .cmpb     (cmpb_w[g]),
            .evt      (e)
        );

        assign sts_set[EVT_PER*g +: EVT_PER]  = e;
        assign irq_gate[EVT_PER*g +: EVT_PER] = {c.ie, 2'b11};
    end

    assign sts_clr = (wr && bank == 2'd3 && word == S_STS) ? bus_wdata[NEVT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            sts_q <= '0;
            msk_q <= '0;
        end else begin
            if (wr && bank == 2'd3 && word == S_CTL) ctl_q <= bus_wdata[CTL_W-1:0];
            if (wr && bank == 2'd3 && word == S_MSK) msk_q <= bus_wdata[NEVT-1:0];
            sts_q <= (sts_q & ~sts_clr) | sts_set;
        end
    end

    assign irq = |(sts_q & msk_q & irq_gate);

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (bank == 2'd3) begin
                case (word)
                    S_CTL:   bus_rdata = DW'(ctl_q);
                    S_STS:   bus_rdata = DW'(sts_q);
                    S_MSK:   bus_rdata = DW'(msk_q);
                    default: bus_rdata = '0;
                endcase
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (bank == 2'(i)) begin
                        case (word)
                            W_CNT:   bus_rdata = cnt_w[i];
                            W_LOAD:  bus_rdata = load_w[i];
                            W_CMPA:  bus_rdata = cmpa_w[i];
                            default: bus_rdata = cmpb_w[i];
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tmr3_chk.sv
module tmr3_chk
    import tmr3_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_en,
    input logic             bus_wr,
    input logic             irq,
    input logic [CTL_W-1:0] ctl_q,
    input logic [NEVT-1:0]  sts_q,
    input logic [NEVT-1:0]  msk_q,
    input logic [NEVT-1:0]  sts_set,
    input logic [NEVT-1:0]  sts_clr,
    input logic [DW-1:0]    cnt0,
    input logic [DW-1:0]    load0
);
    // R1: the cycle after reset ends, no event is pending
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sts_q == '0 && !irq));

    // R6: a set bit not being cleared stays set
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (sts_q & ~sts_clr) != '0 |=>
            ((sts_q & $past(sts_q & ~sts_clr)) == $past(sts_q & ~sts_clr)));

    // R7: an event always lands in status, even under a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        sts_set != '0 |=> ((sts_q & $past(sts_set)) == $past(sts_set)));

    // R8: with every source masked off the line stays low
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        msk_q == '0 |-> !irq);

    // R9: a disabled channel with no bus write holds its count
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q[0] && !(bus_en && bus_wr)) |=> $stable(cnt0));

    // R4: an overflow event leaves the count at the reload value
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        sts_set[2] |=> (cnt0 == $past(load0)));
endmodule

bind tmr3_top tmr3_chk #(.DW(DW)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_en  (bus_en),
    .bus_wr  (bus_wr),
    .irq     (irq),
    .ctl_q   (ctl_q),
    .sts_q   (sts_q),
    .msk_q   (msk_q),
    .sts_set (sts_set),
    .sts_clr (sts_clr),
    .cnt0    (cnt_w[0]),
    .load0   (load_w[0])
);

// File: tb/test_tmr3_top.sv
`timescale 1ns/1ps
module test_tmr3_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    tmr3_top i_tmr3_top (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .irq       (irq)
    );

    // monitor: compare each expected item against what the design shows now
    initial begin
        forever begin
            exp_item_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            checks++;
            if (it.is_irq) begin
                if (irq !== it.exp[0]) begin
                    errors++;
                    $display("FAIL %s irq actual %0b expected %0b", it.tag, irq, it.exp[0]);
                end
            end else if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s addr %h actual %h expected %h", it.tag, bus_addr, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        #0.5;
        bus_en = 1'b0;
    endtask

    task automatic irq_is(input bit e, input string tag);
        exp_item_t it;
        @(negedge clk);
        #1;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h00, 32'h0, "R1 count0");
        rd(8'h24, 32'h0, "R1 load2");
        rd(8'h30, 32'h0, "R1 ctl");
        rd(8'h34, 32'h0, "R1 sts");
        rd(8'h38, 32'h0, "R1 msk");
        irq_is(1'b0, "R1 irq");

        // R2: readback and decode
        wr(8'h14, 32'hAABB_CCDD);
        rd(8'h14, 32'hAABB_CCDD, "R2 load1");
        wr(8'h28, 32'h0000_1234);
        rd(8'h28, 32'h0000_1234, "R2 cmpa2");
        wr(8'h38, 32'h0000_01FF);
        rd(8'h38, 32'h0000_01FF, "R2 msk");
        rd(8'h3C, 32'h0, "R1 unmapped 0x3C");
        rd(8'h16, 32'h0, "R1 unaligned");
        wr(8'h38, 32'h0);

        // R3 / R4: channel 0 up-count, period 3
        wr(8'h00, 32'hFFFF_FFFD);
        wr(8'h04, 32'hFFFF_FFFD);
        wr(8'h30, 32'h0000_0203);
        tick(2);
        rd(8'h00, 32'hFFFF_FFFF, "R3 count0 up");
        rd(8'h34, 32'h0, "R3 no event yet");
        tick(1);
        rd(8'h00, 32'hFFFF_FFFD, "R4 reload");
        rd(8'h34, 32'h0000_0004, "R4 overflow status");

        // R8: overflow gated by interrupt enable
        wr(8'h38, 32'h0000_0004);
        irq_is(1'b0, "R8 ie clear");
        wr(8'h30, 32'h0000_0207);
        irq_is(1'b1, "R8 ie set");

        // R6: write-one-to-clear
        wr(8'h34, 32'h0);
        rd(8'h34, 32'h0000_0004, "R6 zero write no effect");
        wr(8'h34, 32'h0000_0004);
        rd(8'h34, 32'h0, "R6 cleared");
        irq_is(1'b0, "R6 irq dropped");

        // R7: event and clear in one cycle
        wr(8'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h4; ext_tick = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; ext_tick = 1'b0;
        rd(8'h34, 32'h0000_0004, "R7 set wins");
        rd(8'h00, 32'hFFFF_FFFD, "R7 reload alongside");

        // R2: count write wins over a step
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h100; ext_tick = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; ext_tick = 1'b0;
        rd(8'h00, 32'h0000_0100, "R2 count write wins");

        wr(8'h34, 32'h1FF);
        wr(8'h30, 32'h0);
        wr(8'h38, 32'h0);

        // R5: compare events on channel 1
        wr(8'h10, 32'd10);
        wr(8'h18, 32'd12);
        wr(8'h1C, 32'd11);
        wr(8'h30, 32'h0000_0418);
        tick(1);
        rd(8'h10, 32'd11, "R3 count1");
        rd(8'h34, 32'h0000_0010, "R5 compare B");
        tick(1);
        rd(8'h34, 32'h0000_0018, "R5 compare A");
        wr(8'h38, 32'h0000_0008);
        irq_is(1'b1, "R8 compare not gated");

        // R9: freeze and resume
        wr(8'h30, 32'h0);
        tick(2);
        rd(8'h10, 32'd12, "R9 frozen");
        wr(8'h30, 32'h0000_0418);
        tick(1);
        rd(8'h10, 32'd13, "R9 resumed");

        wr(8'h34, 32'h1FF);
        wr(8'h30, 32'h0);
        wr(8'h38, 32'h0);

        // R10: channel 2 down-count
        wr(8'h20, 32'd1);
        wr(8'h24, 32'd5);
        wr(8'h30, 32'h0000_00C0);
        tick(1);
        rd(8'h20, 32'd0, "R10 down step");
        rd(8'h34, 32'h0000_0080, "R5 compare B at zero");
        tick(1);
        rd(8'h20, 32'd5, "R10 reload");
        rd(8'h34, 32'h0000_0180, "R10 overflow status");
        wr(8'h38, 32'h0000_0100);
        wr(8'h30, 32'h0000_01C0);
        irq_is(1'b1, "R8 ch2 overflow");

        wr(8'h34, 32'h1FF);
        wr(8'h38, 32'h0);
        wr(8'h30, 32'h0);

        // R11: prescaled timebase, ext_tick ignored
        wr(8'h00, 32'h0);
        wr(8'h30, 32'h0000_0201);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        #1 snap = bus_rdata;
        for (int i = 0; i < 11; i++) begin
            @(negedge clk); ext_tick = 1'b1;
        end
        ext_tick = 1'b0;
        bus_en = 1'b0;
        rd(8'h00, snap + 32'd2, "R11 one step per six cycles");

        // R11: external timebase
        wr(8'h30, 32'h0000_0203);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        #1 snap = bus_rdata;
        bus_en = 1'b0;
        repeat (12) @(negedge clk);
        rd(8'h00, snap, "R11 external no tick");
        tick(3);
        rd(8'h00, snap + 32'd3, "R11 external ticks");

        @(negedge clk);
        wait (exp_q.size() == 0);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule